// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block is the core of an eight-line interrupt controller. Each request line is captured into a pending-request register. A per-line trigger-mode register decides how capture works. An edge-mode line latches on a rising input. A level-mode line tracks the input. The pending requests that are not masked compete by priority. The priority order is a ring whose starting line is set by a programmable rotation base.

The winning line is offered to the processor only when it strictly outranks the most important interrupt already in service. That comparison uses the same rotation. The surrounding logic acknowledges an interrupt by pulsing an acknowledge strobe with the line number, which marks the line in service. It ends service with an end-of-service strobe. When the instance is a master in nested-cascade mode, the in-service bit of the cascade line can be left out of the in-service comparison. The block resolves priority combinationally and registers the interrupt output.

Top module: `rot_prio_resolver`

## Requirements
- R1: After reset, the pending, in-service, mask, trigger-mode, previous-level and rotation-base registers are all zero, and `win_valid` and `irq_out` are 0.
- R2: For a line in edge mode (trigger bit 0), the pending bit is set only in a cycle where the input is 1 and was 0 in the previous cycle. An input held high after the bit is cleared does not set it again.
- R3: For a line in level mode (trigger bit 1), the pending bit equals the input sampled at the last clock edge, and an acknowledge does not clear it.
- R4: Only pending bits whose mask bit is 0 compete. A masked line never wins.
- R5: Priority ordinal p (0 = highest) belongs to line (p + base) mod 8. `win_idx` is the competing line with the lowest ordinal.
- R6: `win_valid` is 1 only when a line competes and its ordinal is strictly lower than the ordinal of the highest-priority in-service bit. An empty in-service set counts as ordinal 8.
- R7: With parameter IS_MASTER = 1 and `nest_mode` high, in-service bit 2 (the cascade line) is left out of the R6 comparison.
- R8: `irq_out` equals the value `win_valid` had one clock earlier.
- R9: `ack_stb` sets the in-service bit of line `ack_idx` and clears that line's pending bit when it is in edge mode, unless a new rising edge arrives in the same cycle. `eoi_stb` clears the in-service bit of line `eoi_idx`. When both strobes name the same line, the set wins.
- R10: `trig_we` loads `trig_d` ANDed with the writable mask TRIG_WMASK (default 0xF8). Lines 0 to 2 therefore always stay in edge mode.
- R11: `mask_we` loads the mask register from `mask_d`. `base_we` loads the rotation base from `base_d`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 8 | Interrupt request lines |
| mask_we | input | 1 | Load strobe for the mask register |
| mask_d | input | 8 | New mask value (1 = masked) |
| trig_we | input | 1 | Load strobe for the trigger-mode register |
| trig_d | input | 8 | New trigger modes (1 = level, 0 = edge) |
| base_we | input | 1 | Load strobe for the rotation base |
| base_d | input | 3 | New rotation base (line with ordinal 0) |
| ack_stb | input | 1 | Acknowledge: put `ack_idx` in service |
| ack_idx | input | 3 | Line being acknowledged |
| eoi_stb | input | 1 | End of service for `eoi_idx` |
| eoi_idx | input | 3 | Line leaving service |
| nest_mode | input | 1 | Ignore the cascade line's in-service bit (master only) |
| win_idx | output | 3 | Line index of the best competing request |
| win_valid | output | 1 | The winner outranks every line in service |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The hardest state to reach is one where the in-service and pending sets overlap under a rotated base. Such a state exposes the strict-versus-equal ordinal comparison, and the exclusion of the cascade line under nested mode. Directed sequences build these states on purpose. One keeps a level line asserted while it is in service. Another puts line 2 in service and then raises a lower-priority level line with `nest_mode` toggled. The random phase acknowledges whichever line the bench expects to win, so in-service bits pile up along the rotation. Meanwhile it rewrites the base, mask and trigger modes.

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver #(
  parameter int N = 8,
  parameter logic [N-1:0] TRIG_WMASK = 8'hF8,
  parameter bit IS_MASTER = 1'b1,
  parameter int CASCADE_LINE = 2,
  localparam int IW = $clog2(N),
  localparam int OW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_in,
  input  logic          mask_we,
  input  logic [N-1:0]  mask_d,
  input  logic          trig_we,
  input  logic [N-1:0]  trig_d,
  input  logic          base_we,
  input  logic [IW-1:0] base_d,
  input  logic          ack_stb,
  input  logic [IW-1:0] ack_idx,
  input  logic          eoi_stb,
  input  logic [IW-1:0] eoi_idx,
  input  logic          nest_mode,
  output logic [IW-1:0] win_idx,
  output logic          win_valid,
  output logic          irq_out
);

  logic [N-1:0]  irr_q, isr_q, imr_q, trig_q, last_q;
  logic [IW-1:0] base_q;
  logic          irq_q;

  function automatic logic [OW-1:0] first_ord(input logic [N-1:0] v, input logic [IW-1:0] b);
    first_ord = OW'(N);
    for (int p = N - 1; p >= 0; p--) begin
      logic [IW-1:0] ln;
      ln = IW'(p) + b;
      if (v[ln]) first_ord = OW'(p);
    end
  endfunction

  logic [N-1:0] ack_oh, eoi_oh, rise, irr_nxt, isr_nxt, nest_oh;
  assign ack_oh  = ack_stb ? (N'(1) << ack_idx) : '0;
  assign eoi_oh  = eoi_stb ? (N'(1) << eoi_idx) : '0;
  assign rise    = req_in & ~last_q;
  assign irr_nxt = (trig_q & req_in) | (~trig_q & ((irr_q & ~ack_oh) | rise));
  assign isr_nxt = (isr_q & ~eoi_oh) | ack_oh;
  assign nest_oh = (IS_MASTER && nest_mode) ? (N'(1) << CASCADE_LINE) : '0;

  logic [OW-1:0] pend_ord, cur_ord;
  assign pend_ord  = first_ord(irr_q & ~imr_q, base_q);
  assign cur_ord   = first_ord(isr_q & ~nest_oh, base_q);
  assign win_valid = pend_ord < cur_ord;
  assign win_idx   = pend_ord[IW-1:0] + base_q;
  assign irq_out   = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      imr_q  <= '0;
      trig_q <= '0;
      last_q <= '0;
      base_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      last_q <= req_in;
      irr_q  <= irr_nxt;
      isr_q  <= isr_nxt;
      irq_q  <= win_valid;
      if (mask_we) imr_q <= mask_d;
      if (trig_we) trig_q <= trig_d & TRIG_WMASK;
      if (base_we) base_q <= base_d;
    end
  end

endmodule

// File: rtl/rot_prio_resolver_chk.sv
module rot_prio_resolver_chk #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req_in,
  input logic [N-1:0]  irr_q,
  input logic [N-1:0]  isr_q,
  input logic [N-1:0]  imr_q,
  input logic [N-1:0]  trig_q,
  input logic [N-1:0]  last_q,
  input logic          ack_stb,
  input logic [IW-1:0] ack_idx,
  input logic          eoi_stb,
  input logic [IW-1:0] eoi_idx,
  input logic [IW-1:0] win_idx,
  input logic          win_valid,
  input logic          irq_out
);

  assert_level_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((irr_q ^ $past(req_in)) & $past(trig_q)) == '0);

  assert_edge_needs_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irr_q & ~$past(irr_q) & ~$past(trig_q) & ~($past(req_in) & ~$past(last_q))) == '0);

  assert_winner_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (irr_q[win_idx] && !imr_q[win_idx]));

  assert_irq_registered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> irq_out == $past(win_valid));

  assert_eoi_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_stb && !(ack_stb && ack_idx == eoi_idx)) |=> !isr_q[$past(eoi_idx)]);

  assert_ack_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |=> isr_q[$past(ack_idx)]);

endmodule

bind rot_prio_resolver rot_prio_resolver_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_in(req_in), .irr_q(irr_q), .isr_q(isr_q),
  .imr_q(imr_q), .trig_q(trig_q), .last_q(last_q), .ack_stb(ack_stb),
  .ack_idx(ack_idx), .eoi_stb(eoi_stb), .eoi_idx(eoi_idx), .win_idx(win_idx),
  .win_valid(win_valid), .irq_out(irq_out)
);

// File: tb/rot_prio_resolver_bench.sv
module rot_prio_resolver_bench;
  localparam logic [7:0] WMASK = 8'hF8;

  logic clk = 0, rst_n = 0;
  logic [7:0] req_in = 0, mask_d = 0, trig_d = 0;
  logic mask_we = 0, trig_we = 0, base_we = 0, ack_stb = 0, eoi_stb = 0, nest_mode = 0;
  logic [2:0] base_d = 0, ack_idx = 0, eoi_idx = 0;
  logic [2:0] win_idx;
  logic win_valid, irq_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rot_prio_resolver u_rot_prio_resolver (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .mask_we(mask_we), .mask_d(mask_d),
    .trig_we(trig_we), .trig_d(trig_d), .base_we(base_we), .base_d(base_d),
    .ack_stb(ack_stb), .ack_idx(ack_idx), .eoi_stb(eoi_stb), .eoi_idx(eoi_idx),
    .nest_mode(nest_mode), .win_idx(win_idx), .win_valid(win_valid), .irq_out(irq_out)
  );

  logic [7:0] m_irr, m_isr, m_imr, m_trig, m_last;
  logic [2:0] m_base;
  logic m_irq;

  function automatic int ord_of(input logic [7:0] v, input logic [2:0] b);
    for (int p = 0; p < 8; p++) if (v[(p + b) % 8]) return p;
    return 8;
  endfunction

  function automatic bit exp_valid();
    logic [7:0] ins = m_isr;
    if (nest_mode) ins[2] = 1'b0;
    return ord_of(m_irr & ~m_imr, m_base) < ord_of(ins, m_base);
  endfunction

  function automatic logic [2:0] exp_idx();
    return 3'((ord_of(m_irr & ~m_imr, m_base) + m_base) % 8);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_irr <= 0; m_isr <= 0; m_imr <= 0; m_trig <= 0; m_last <= 0; m_base <= 0; m_irq <= 0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        if (m_trig[i]) m_irr[i] <= req_in[i];
        else if (req_in[i] && !m_last[i]) m_irr[i] <= 1'b1;
        else if (ack_stb && ack_idx == 3'(i)) m_irr[i] <= 1'b0;
        if (ack_stb && ack_idx == 3'(i)) m_isr[i] <= 1'b1;
        else if (eoi_stb && eoi_idx == 3'(i)) m_isr[i] <= 1'b0;
      end
      m_last <= req_in;
      m_irq <= exp_valid();
      if (mask_we) m_imr <= mask_d;
      if (trig_we) m_trig <= trig_d & WMASK;
      if (base_we) m_base <= base_d;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst_n) begin
      chk("R6 model win_valid", win_valid, exp_valid());
      if (exp_valid()) chk("R5 model win_idx", win_idx, exp_idx());
      chk("R8 model irq_out", irq_out, m_irq);
    end
    mask_we = 0; trig_we = 0; base_we = 0; ack_stb = 0; eoi_stb = 0;
  endtask

  task automatic ack(input int l);
    ack_stb = 1; ack_idx = 3'(l); tick();
  endtask

  task automatic eoi(input int l);
    eoi_stb = 1; eoi_idx = 3'(l); tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    chk("R1 reset win_valid", win_valid, 0);
    chk("R1 reset irq_out", irq_out, 0);
    rst_n = 1;
    tick();
    // R2 edge capture and no re-set while held high
    req_in = 8'h08; tick();
    chk("R2 rise sets line 3", {win_valid, win_idx}, {1'b1, 3'd3});
    tick();
    chk("R8 irq follows", irq_out, 1);
    ack(3);
    chk("R9 ack clears edge request", win_valid, 0);
    tick(); tick();
    eoi(3);
    chk("R2 held high no re-set", win_valid, 0);
    req_in = 0; tick(); req_in = 8'h08; tick();
    chk("R2 new rise", {win_valid, win_idx}, {1'b1, 3'd3});
    ack(3); eoi(3);
    req_in = 0; tick();
    // R3 level, R6 equal ordinal, R10 write mask
    trig_d = 8'hFF; trig_we = 1; tick();
    req_in = 8'h10; tick();
    chk("R3 level sets line 4", {win_valid, win_idx}, {1'b1, 3'd4});
    ack(4);
    chk("R6 equal ordinal blocks", win_valid, 0);
    eoi(4);
    chk("R3 level kept after ack", {win_valid, win_idx}, {1'b1, 3'd4});
    req_in = 0; tick();
    chk("R3 level follows low", win_valid, 0);
    req_in = 8'h01; tick(); req_in = 0; tick();
    chk("R10 line 0 stays edge", {win_valid, win_idx}, {1'b1, 3'd0});
    ack(0); eoi(0);
    // R5 rotation with level lines 4 and 6
    req_in = 8'h50; tick();
    chk("R5 base 0", win_idx, 4);
    base_d = 5; base_we = 1; tick();
    chk("R11 R5 base 5", win_idx, 6);
    base_d = 7; base_we = 1; tick();
    chk("R5 base 7", win_idx, 4);
    base_d = 5; base_we = 1; tick();
    mask_d = 8'h40; mask_we = 1; tick();
    chk("R4 R11 masked 6", {win_valid, win_idx}, {1'b1, 3'd4});
    mask_d = 8'h50; mask_we = 1; tick();
    chk("R4 all masked", win_valid, 0);
    mask_d = 0; mask_we = 1; base_d = 0; base_we = 1; req_in = 0; tick();
    // R7 nested: line 2 in service, level line 4 requests
    req_in = 8'h04; tick(); ack(2); req_in = 8'h10; tick();
    chk("R7 nest off blocks", win_valid, 0);
    nest_mode = 1; tick();
    chk("R7 nest on grants", {win_valid, win_idx}, {1'b1, 3'd4});
    nest_mode = 0; eoi(2); req_in = 0; tick();
    // random phase
    for (int k = 0; k < 4000; k++) begin
      req_in = req_in ^ 8'($urandom & $urandom & $urandom);
      if ($urandom_range(0, 3) == 0 && exp_valid()) begin ack_stb = 1; ack_idx = exp_idx(); end
      if ($urandom_range(0, 4) == 0) begin eoi_stb = 1; eoi_idx = 3'($urandom); end
      if ($urandom_range(0, 40) == 0) begin mask_we = 1; mask_d = 8'($urandom & $urandom); end
      if ($urandom_range(0, 30) == 0) begin base_we = 1; base_d = 3'($urandom); end
      if ($urandom_range(0, 60) == 0) begin trig_we = 1; trig_d = 8'($urandom); end
      if ($urandom_range(0, 20) == 0) nest_mode = ~nest_mode;
      tick();
    end
    finish_run();
  end
endmodule